// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is an I2C slave that fronts a byte-wide memory. It oversamples SCL and SDA with the system clock and finds Start and Stop conditions. It then compares the 7-bit device address and acknowledges only its own. A single address pointer lives inside the block and is kept between transactions. Writes and reads share it, so a read that carries no address phase carries on from where the previous transfer stopped.

A write sends the device address with the direction bit cleared, then a high and a low address byte, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. A selective read sends the same address phase with no data, then a repeated Start and the device address with the direction bit set. A current-address read skips the address phase entirely. The pointer advances after every byte in either direction and wraps from the top of memory to zero.

The memory depth is 2^ADDR_W bytes. The default is 2 KB; ADDR_W = 13 gives 8 KB. SDA is open-drain: the block only ever pulls it low, through an output enable.

Top module: `i2cmem_top`

## Requirements
- R1: A Stop condition, where SDA rises while SCL is high, returns the slave to idle with SDA released in the next clock. A Start condition, where SDA falls while SCL is high, restarts device-address reception from any state.
- R2: The device address is compared with parameter DEV_ADDR (default 7'h50), and bit 0 of the address byte selects the direction (0 = write, 1 = read).
  - If the address matches, the slave acknowledges by pulling SDA low during the 9th clock.
  - If it does not match, the slave gives no acknowledge, drives nothing, and ignores all traffic until the next Start.
- R3: A write transaction is made of: the device address with bit 0 = 0, an address high byte, an address low byte, then data bytes.
  - The slave acknowledges every one of these bytes.
  - Each data byte is stored at the current pointer.
- R4: The pointer advances by one after every data byte written or read. From address 2^ADDR_W-1 it wraps to 0.
- R5: A read with no address phase returns data starting at the byte immediately after the last byte written or read.
- R6: A selective read loads the pointer without storing any data. The read that follows a repeated Start begins at the loaded address.
- R7: During a read, data bits go out MSB first.
  - If the master acknowledges in the 9th clock (SDA low), the next sequential byte follows.
  - If the master does not acknowledge (SDA high), the slave releases SDA and goes idle.
- R8: Each of these four endings of a read leaves SDA released and the pointer one past the last byte sent: no acknowledge then Stop; no acknowledge then Start; Stop in the 9th clock; Start in the 9th clock.
- R9: SDA only becomes pulled low while SCL is low.
- R10: Synchronous reset sets the pointer to 0 and releases SDA. Memory contents are kept through reset.
- R11: Bits of the address high byte at and above position ADDR_W-8 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus value) |
| sda_oe_o | output | 1 | When high, the slave pulls SDA low |

## Verification
The embedded assertions check several rules on every cycle:
- a Stop always releases SDA and a missed address always leads to idle;
- the pointer only holds, steps by one, or is loaded during an address byte;
- a master's missing acknowledge releases the bus;
- SDA is never newly pulled low while SCL is high.

Only the bench's scenarios can show that stored bytes come back at the right addresses. The same goes for the persistent pointer after writes, after reads and after each of the four read endings. Wrap-around, masking of the high address bits, and memory surviving a mid-run reset are also shown only by the scenarios. These are checked against a behavioural memory and pointer model, and the slave's SDA enable is compared with the model's expectation on every clock while SCL is high.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } i2cm_state_e;
endpackage

// File: rtl/i2cmem_busmon.sv
module i2cmem_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2cmem_ram.sv
module i2cmem_ram #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/i2cmem_engine.sv
module i2cmem_engine
  import i2cmem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         ADDR_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        ram_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              sda_oe
);
  i2cm_state_e       state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txbyte;
  logic [ADDR_W-1:0] ptr, waddr;
  logic              mack;
  logic              ld_evt;
  logic              rx_state;

  assign rx_state = (state == ST_DEV) || (state == ST_AHI) ||
                    (state == ST_ALO) || (state == ST_WDAT);
  assign ld_evt   = scl_fall && (bitcnt == 4'd8) && !start_det && !stop_det &&
                    ((state == ST_AHI) || (state == ST_ALO));
  assign mem_addr = mem_we ? waddr : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txbyte    <= '0;
      ptr       <= '0;
      waddr     <= '0;
      mack      <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      sda_oe    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (scl_fall && bitcnt == 4'd9) begin
        // end of the slave acknowledge slot
        bitcnt <= '0;
        if (state == ST_RDAT) begin
          txbyte <= ram_q;
          sda_oe <= ~ram_q[7];
        end else begin
          sda_oe <= 1'b0;
        end
      end else if (rx_state) begin
        if (scl_rise && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_lvl};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          case (state)
            ST_DEV: begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                state  <= shreg[0] ? ST_RDAT : ST_AHI;
              end else begin
                state  <= ST_IDLE;
                bitcnt <= '0;
              end
            end
            ST_AHI: begin
              ptr[ADDR_W-1:8] <= shreg[ADDR_W-9:0];
              sda_oe          <= 1'b1;
              state           <= ST_ALO;
            end
            ST_ALO: begin
              ptr[7:0] <= shreg;
              sda_oe   <= 1'b1;
              state    <= ST_WDAT;
            end
            default: begin
              mem_we    <= 1'b1;
              mem_wdata <= shreg;
              waddr     <= ptr;
              ptr       <= ptr + 1'b1;
              sda_oe    <= 1'b1;
            end
          endcase
        end
      end else if (state == ST_RDAT) begin
        if (scl_fall && bitcnt < 4'd7) begin
          txbyte <= {txbyte[6:0], 1'b0};
          sda_oe <= ~txbyte[6];
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd7) begin
          sda_oe <= 1'b0;
          bitcnt <= 4'd8;
        end else if (scl_rise && bitcnt == 4'd8) begin
          mack <= ~sda_lvl;
          ptr  <= ptr + 1'b1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          bitcnt <= '0;
          if (mack) begin
            txbyte <= ram_q;
            sda_oe <= ~ram_q[7];
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_IDLE;
          end
        end
      end
    end
  end

  // R1: Stop always releases the bus and idles
  p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
    stop_det && !start_det |=> !sda_oe && state == ST_IDLE);

  // R2: a missed device address leads to idle with no acknowledge
  p_nomatch_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_DEV && scl_fall && bitcnt == 4'd8 && shreg[7:1] != DEV_ADDR &&
    !start_det && !stop_det |=> state == ST_IDLE && !sda_oe);

  // R4: pointer holds, steps by one, or is loaded in an address byte
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    !ld_evt |=> (ptr == $past(ptr)) || (ptr == $past(ptr) + 1'b1));

  // R7: a missing master acknowledge releases SDA
  p_nack_release_r7: assert property (@(posedge clk) disable iff (rst)
    state == ST_RDAT && scl_fall && bitcnt == 4'd8 && !mack &&
    !start_det && !stop_det |=> !sda_oe && state == ST_IDLE);

  // R9: SDA is only newly pulled low while SCL is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);
endmodule

// File: rtl/i2cmem_top.sv
module i2cmem_top #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 11,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [7:0]        mem_wdata, ram_q;

  i2cmem_busmon #(.STAGES(SYNC_STAGES)) u_busmon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2cmem_engine #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .ram_q(ram_q), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .sda_oe(sda_oe_o)
  );

  i2cmem_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(ram_q)
  );
endmodule

// File: tb/i2cmem_top_tb.sv
`timescale 1ns/1ps
module i2cmem_top_tb;
  localparam int AW   = 11;
  localparam int MASK = (1 << AW) - 1;
  localparam int HP   = 20;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe_o;
  wire  sda_bus = sda_m & ~sda_oe_o;

  logic exp_oe = 1'b0;
  logic chk_en = 1'b0;
  int   nchk = 0;
  int   nerr = 0;
  logic [7:0] model [0:MASK];
  int   mptr = 0;

  always #10 clk = ~clk;

  i2cmem_top #(.DEV_ADDR(DEV), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // every clock with SCL high, the slave's SDA enable must equal the model's
  always @(negedge clk) begin
    if (chk_en && scl && !rst)
      chk(sda_oe_o === exp_oe, "R9/R7 sda_oe vs model", int'(sda_oe_o), int'(exp_oe));
  end

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clk_bit(output logic s);
    hold(HP/2);
    scl = 1'b1;
    hold(HP/2);
    @(negedge clk);
    s = sda_bus;
    hold(HP/2);
    scl = 1'b0;
  endtask

  task automatic do_start();
    exp_oe = 1'b0;
    sda_m = 1'b1; hold(HP/2);
    scl = 1'b1;   hold(HP/2);
    sda_m = 1'b0; hold(HP/2);
    scl = 1'b0;   hold(HP/2);
  endtask

  task automatic do_stop();
    exp_oe = 1'b0;
    sda_m = 1'b0; hold(HP/2);
    scl = 1'b1;   hold(HP/2);
    sda_m = 1'b1; hold(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack_exp, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      exp_oe = 1'b0;
      sda_m = b[i];
      clk_bit(s);
    end
    sda_m = 1'b1;
    exp_oe = ack_exp;
    clk_bit(s);
    chk((!s) == ack_exp, tag, int'(!s), int'(ack_exp));
    exp_oe = 1'b0;
  endtask

  task automatic rd_bits(input logic [7:0] e, input string tag);
    logic s;
    logic [7:0] got;
    got = '0;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      exp_oe = ~e[i];
      clk_bit(s);
      got[i] = s;
    end
    exp_oe = 1'b0;
    chk(got == e, tag, int'(got), int'(e));
  endtask

  task automatic master_ack(input logic a);
    logic s;
    exp_oe = 1'b0;
    sda_m = ~a;
    clk_bit(s);
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [15:0] addr, input logic [7:0] d [], input string tag);
    do_start();
    send_byte({DEV, 1'b0}, 1'b1, {tag, " R2 dev ack"});
    send_byte(addr[15:8], 1'b1, {tag, " R3 ahi ack"});
    send_byte(addr[7:0], 1'b1, {tag, " R3 alo ack"});
    mptr = int'(addr) & MASK;
    foreach (d[i]) begin
      send_byte(d[i], 1'b1, {tag, " R3 data ack"});
      model[mptr] = d[i];
      mptr = (mptr + 1) & MASK;
    end
    do_stop();
  endtask

  // mode 0 NACK+Stop, 1 NACK+Start, 2 Stop in 9th clock, 3 Start in 9th clock
  task automatic rd_body(input int n, input int mode, input string tag);
    for (int i = 0; i < n; i++) begin
      rd_bits(model[mptr], tag);
      mptr = (mptr + 1) & MASK;
      if (i < n - 1) master_ack(1'b1);
      else begin
        case (mode)
          0: begin master_ack(1'b0); do_stop(); end
          1: begin master_ack(1'b0); do_start(); do_stop(); end
          2: do_stop();
          default: begin do_start(); do_stop(); end
        endcase
      end
    end
  endtask

  task automatic cur_rd(input int n, input int mode, input string tag);
    do_start();
    send_byte({DEV, 1'b1}, 1'b1, {tag, " R2 dev ack"});
    rd_body(n, mode, tag);
  endtask

  task automatic sel_rd(input logic [15:0] addr, input int n, input int mode, input string tag);
    do_start();
    send_byte({DEV, 1'b0}, 1'b1, {tag, " R6 dev ack"});
    send_byte(addr[15:8], 1'b1, {tag, " R6 ahi ack"});
    send_byte(addr[7:0], 1'b1, {tag, " R6 alo ack"});
    mptr = int'(addr) & MASK;
    do_start();
    send_byte({DEV, 1'b1}, 1'b1, {tag, " R6 dev rd ack"});
    rd_body(n, mode, tag);
  endtask

  initial begin
    logic [7:0] d [];
    hold(4);
    rst = 1'b0;
    hold(2);
    @(negedge clk);
    chk(sda_oe_o == 1'b0, "R10 reset releases SDA", int'(sda_oe_o), 0);
    chk_en = 1'b1;
    scl = 1'b0;
    hold(HP);

    // R3 R4: multi-byte write
    d = new[16];
    foreach (d[i]) d[i] = 8'hA0 ^ (8'(i) * 8'h17);
    wr_txn(16'h0010, d, "R3 write burst");

    // R6 R7 R8: selective read then every termination with current reads (R5)
    sel_rd(16'h0011, 3, 0, "R6 selective read nack+stop R8");
    cur_rd(2, 1, "R5 current read nack+start R8");
    cur_rd(1, 2, "R8 stop in 9th clock");
    cur_rd(2, 3, "R8 start in 9th clock");
    cur_rd(1, 0, "R5 continue after terminations");

    // R2: foreign device address is ignored, including its data bytes
    do_start();
    send_byte({7'h51, 1'b0}, 1'b0, "R2 foreign addr no ack");
    send_byte(8'h00, 1'b0, "R2 ignored byte");
    send_byte(8'h12, 1'b0, "R2 ignored byte");
    send_byte(8'h55, 1'b0, "R2 ignored byte");
    do_stop();
    do_start();
    send_byte({7'h51, 1'b1}, 1'b0, "R2 foreign read no ack");
    do_stop();
    sel_rd(16'h0012, 1, 0, "R2 memory unchanged after foreign write");

    // R4: wrap at top of memory
    d = new[3];
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
    wr_txn(16'h07FE, d, "R4 write across top");
    sel_rd(16'h07FF, 2, 0, "R4 read across top");

    // R11: upper address bits ignored
    d = new[1];
    d[0] = 8'h5A;
    wr_txn(16'hFA10, d, "R11 write masked addr");
    sel_rd(16'h0210, 1, 0, "R11 read masked addr");

    // R5: current read after a write continues at the next byte
    d = new[2];
    d[0] = 8'h01; d[1] = 8'h02;
    wr_txn(16'h0030, d, "R5 setup");
    d = new[1];
    d[0] = 8'h09;
    wr_txn(16'h0030, d, "R5 single write");
    cur_rd(1, 0, "R5 read after write");

    // R10: mid-run reset clears pointer, keeps memory
    hold(4);
    rst = 1'b1;
    hold(3);
    rst = 1'b0;
    hold(2);
    @(negedge clk);
    chk(sda_oe_o == 1'b0, "R10 SDA released after reset", int'(sda_oe_o), 0);
    mptr = 0;
    cur_rd(1, 0, "R10 pointer zero after reset");

    hold(20);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule